// File: doc/BRIEF.md
# Serial Command Sequencer for a Four-Input SAR Converter

This block runs the host side of a synchronous serial link to a 16-bit successive-approximation converter with four analog inputs. A command arrives on a valid/ready port. It carries a channel number, the choice between single-ended and differential input, a two-bit power setting and a framing choice. The sequencer divides the system clock down to a serial clock and drives chip select. It sends an eight-bit control word on the host-to-converter line and shifts in the 16-bit conversion result from the converter-to-host line. It then presents the result for one system cycle, together with the channel number of the command that produced it.

The converter spends one serial clock on its first bit decision after the control word ends. The result therefore starts in the tenth serial clock of a frame and ends in the twenty-fifth. Short framing hides that extra clock. When another command is waiting as the twenty-fourth clock closes, its start bit shares the twenty-fifth clock with the incoming LSB, so back-to-back conversions cost 24 clocks each. Long framing always runs 32 clocks and disregards everything that arrives after the LSB.

Command port back-pressure: a command is taken on any system cycle where both `cmd_valid` and `cmd_ready` are high. The issuer must hold `cmd_valid` and all command fields steady until that cycle. A command presented while a frame is running is neither lost nor taken early. The result port has no ready signal, so the consumer must take every `res_valid` pulse as it comes.

Top module: `sar_serial_host`

## Requirements
- R1: While reset is asserted and directly after it, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_mosi` is 0, `res_valid` is 0 and `cmd_ready` is 1.
- R2: The control word goes out MSB first during serial clocks 1 to 8 of a frame. Bit 7 is a start bit of 1, bits 6:4 are `cmd_chan`, bit 3 is 0, bit 2 is `cmd_single` (1 = single-ended, 0 = differential), and bits 1:0 are `cmd_pwr`, passed through unchanged (11 full power, 00 power down between conversions, 10 internal conversion clock, 01 external conversion clock).
- R3: `adc_sclk` is low whenever `adc_cs_n` is high. Each high phase and each low phase lasts `DIV_HALF` system cycles. `adc_mosi` changes only where `adc_sclk` falls or `adc_cs_n` falls. `adc_miso` is sampled just before `adc_sclk` rises.
- R4: The result bits are sampled at the rising edges of serial clocks 10 through 25 of a frame, MSB first. They are presented unchanged as straight binary on `res_data`.
- R5: In short framing (`cmd_long` = 0), `cmd_ready` rises for the single system cycle in which clock 24 falls. A command taken in that cycle begins at once: its start bit occupies clock 25 of the previous frame, where the previous LSB is sampled, and `adc_cs_n` stays low. Each overlapped conversion thus costs 24 clocks.
- R6: If no command is taken at that point, a short frame runs a 25th clock with `adc_mosi` low and then raises `adc_cs_n`. A chip-select window that holds n short conversions therefore counts 24n+1 rising edges.
- R7: In long framing (`cmd_long` = 1), a frame runs exactly 32 clocks, `adc_mosi` stays 0 after the control word, and values on `adc_miso` in clocks 26 to 32 do not affect the result. `adc_cs_n` then rises. A window of k overlapped short conversions followed by a long one counts 24k+32 rising edges.
- R8: Every conversion produces exactly one `res_valid` pulse, one system cycle wide, while `adc_sclk` is high and `adc_cs_n` is low. `res_chan` equals the channel of the command that produced it, and results come out in command order.
- R9: While a frame runs, `cmd_ready` is 0 except in the overlap cycle of R5. A command held during a long frame or a short frame is taken only at the next ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_chan | input | 3 | Channel select code |
| cmd_single | input | 1 | 1 = single-ended, 0 = differential |
| cmd_pwr | input | 2 | Power setting sent in the control word |
| cmd_long | input | 1 | 1 = 32-clock framing, 0 = 24-clock overlapped framing |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idle low |
| adc_mosi | output | 1 | Control data to converter |
| adc_miso | input | 1 | Result data from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Conversion result, straight binary |
| res_chan | output | 3 | Channel of the command that produced the result |

## Verification
The properties assume that the command issuer obeys the hold rule, keeping `cmd_valid` and the command fields still until the handshake. They also assume the converter changes `adc_miso` only at falling serial-clock edges, and that result pulses never need to be stalled. The stimulus issues commands only from a negative-clock-edge task that waits for `cmd_ready`. A behavioural converter model updates `adc_miso` solely on `adc_sclk` falling edges. Nothing in the bench withholds results. The model deliberately drives ones during long-frame padding, so that ignored bits would corrupt a wrongly captured result.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;
  localparam int CTRL_W = 8;
  localparam int PWR_W  = 2;

  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } host_state_e;

  // Control word: start, channel, spare zero, input mode, power setting.
  function automatic logic [CTRL_W-1:0] make_ctrl(input logic [2:0] chan,
                                                  input logic       single,
                                                  input logic [PWR_W-1:0] pwr);
    return {1'b1, chan, 1'b0, single, pwr};
  endfunction
endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_ctrl_shift.sv
module sar_ctrl_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         ser_out
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign ser_out = sr[W-1];
endmodule

// File: rtl/sar_res_capture.sv
module sar_res_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (sample) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/sar_serial_host.sv
module sar_serial_host
  import sar_host_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int RES_W    = 16,
  parameter int CHAN_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic              cmd_single,
  input  logic [PWR_W-1:0]  cmd_pwr,
  input  logic              cmd_long,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_mosi,
  input  logic              adc_miso,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [CHAN_W-1:0] res_chan
);
  // Frame positions, counted in serial clocks from 1.
  localparam int LONG_LEN = 4 * CTRL_W;
  localparam int POS_W    = $clog2(LONG_LEN + 1);
  localparam logic [POS_W-1:0] P_ONE  = POS_W'(1);
  localparam logic [POS_W-1:0] P_MSB  = POS_W'(CTRL_W + 2);
  localparam logic [POS_W-1:0] P_LSB  = POS_W'(CTRL_W + 1 + RES_W);
  localparam logic [POS_W-1:0] P_SLOT = POS_W'(CTRL_W + RES_W);
  localparam logic [POS_W-1:0] P_LONG = POS_W'(LONG_LEN);

  host_state_e       state;
  logic              cs_n_q, sclk_q, frame_long, lsb_due, res_valid_q;
  logic [POS_W-1:0]  pos, end_pos;
  logic [CHAN_W-1:0] cur_chan, prev_chan, res_chan_q;
  logic              tick, rise, fall, slot, accept, take_bit, last_bit;
  logic [2:0]        chan3;

  sar_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk_gen (
    .clk(clk), .rst_n(rst_n), .run(state == ST_RUN), .tick(tick)
  );

  assign rise    = tick && !sclk_q;
  assign fall    = tick &&  sclk_q;
  assign slot    = fall && (pos == P_SLOT) && !frame_long;
  assign cmd_ready = (state == ST_IDLE) || slot;
  assign accept  = cmd_valid && cmd_ready;
  assign end_pos = frame_long ? P_LONG : P_LSB;

  assign last_bit = rise && ((pos == P_LSB) || (lsb_due && pos == P_ONE));
  assign take_bit = last_bit || (rise && pos >= P_MSB && pos < P_LSB);

  assign chan3 = 3'(cmd_chan);

  sar_ctrl_shift #(.W(CTRL_W)) u_ctrl_shift (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val(make_ctrl(chan3, cmd_single, cmd_pwr)),
    .shift(fall), .ser_out(adc_mosi)
  );

  sar_res_capture #(.W(RES_W)) u_res_capture (
    .clk(clk), .rst_n(rst_n), .sample(take_bit), .bit_in(adc_miso),
    .word(res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cs_n_q      <= 1'b1;
      sclk_q      <= 1'b0;
      pos         <= '0;
      frame_long  <= 1'b0;
      lsb_due     <= 1'b0;
      cur_chan    <= '0;
      prev_chan   <= '0;
      res_chan_q  <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= last_bit;
      if (last_bit)
        res_chan_q <= (lsb_due && pos == P_ONE) ? prev_chan : cur_chan;
      if (accept) begin
        prev_chan  <= cur_chan;
        cur_chan   <= cmd_chan;
        frame_long <= cmd_long;
      end
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_RUN;
            cs_n_q  <= 1'b0;
            pos     <= P_ONE;
            lsb_due <= 1'b0;
          end
        end
        ST_RUN: begin
          if (rise) begin
            sclk_q <= 1'b1;
            if (lsb_due && pos == P_ONE) lsb_due <= 1'b0;
          end
          if (fall) begin
            sclk_q <= 1'b0;
            if (accept) begin
              pos     <= P_ONE;
              lsb_due <= 1'b1;
            end else if (pos == end_pos) begin
              state  <= ST_IDLE;
              cs_n_q <= 1'b1;
              pos    <= '0;
            end else begin
              pos <= pos + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adc_cs_n  = cs_n_q;
  assign adc_sclk  = sclk_q;
  assign res_valid = res_valid_q;
  assign res_chan  = res_chan_q;
endmodule

// File: rtl/sar_serial_host_chk.sv
module sar_serial_host_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic adc_mosi,
  input logic res_valid
);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  assert_mosi_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_mosi) |-> ($fell(adc_sclk) || $fell(adc_cs_n)));

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (adc_mosi && !adc_cs_n));

  assert_overlap_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !adc_cs_n) |-> adc_sclk);

  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_strobe_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (adc_sclk && !adc_cs_n));
endmodule

bind sar_serial_host sar_serial_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_mosi(adc_mosi),
  .res_valid(res_valid)
);

// File: tb/sar_serial_host_tb.sv
`timescale 1ns/1ps
module sar_serial_host_tb;
  localparam int DIV   = 3;
  localparam int NVEC  = 11;
  localparam int NWIN  = 5;
  // {chan[22:20], single[19], pwr[18:17], long[16], code[15:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 2'b11, 1'b0, 16'h0000},
    {3'd3, 1'b1, 2'b00, 1'b0, 16'hFFFF},
    {3'd5, 1'b0, 2'b10, 1'b0, 16'h8001},
    {3'd2, 1'b1, 2'b01, 1'b1, 16'h7FFE},
    {3'd1, 1'b0, 2'b11, 1'b0, 16'hA5C3},
    {3'd7, 1'b1, 2'b00, 1'b0, 16'h1234},
    {3'd4, 1'b0, 2'b01, 1'b1, 16'h5A5A},
    {3'd6, 1'b1, 2'b10, 1'b0, 16'hC0DE},
    {3'd7, 1'b0, 2'b11, 1'b1, 16'hFFFF},
    {3'd0, 1'b0, 2'b11, 1'b0, 16'h0F0F},
    {3'd6, 1'b1, 2'b00, 1'b0, 16'hF00F}
  };
  localparam int EXP_WIN [NWIN] = '{104, 80, 25, 32, 49};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_single = 1'b0, cmd_long = 1'b0;
  logic [2:0] cmd_chan = '0;
  logic [1:0] cmd_pwr = '0;
  logic adc_miso = 1'b0;
  logic cmd_ready, adc_cs_n, adc_sclk, adc_mosi, res_valid;
  logic [15:0] res_data;
  logic [2:0]  res_chan;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  sar_serial_host #(.DIV_HALF(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_single(cmd_single), .cmd_pwr(cmd_pwr),
    .cmd_long(cmd_long), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_mosi(adc_mosi), .adc_miso(adc_miso), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan)
  );

  // Converter model plus chip-select window recorder.
  logic [7:0] got_byte [NVEC];
  int got_win [NWIN];
  int m_idx = 0, n_win = 0, coll = 0, fcnt = 0, win_cnt = 0;
  logic armed = 1'b0, cur_long = 1'b0;
  logic [7:0]  sb = '0;
  logic [15:0] cur_code = '0;

  always @(posedge adc_sclk or negedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      if (win_cnt != 0 && n_win < NWIN) begin
        got_win[n_win] = win_cnt;
        n_win++;
      end
      win_cnt = 0; coll = 0; armed = 1'b0; adc_miso = 1'b0;
    end else if (adc_sclk) begin
      win_cnt++;
      if (coll == 0) begin
        if (adc_mosi) begin coll = 1; sb = 8'h01; end
      end else begin
        sb = {sb[6:0], adc_mosi};
        coll++;
        if (coll == 8) begin
          if (m_idx < NVEC) begin
            got_byte[m_idx] = sb;
            cur_code = VEC[m_idx][15:0];
            cur_long = VEC[m_idx][16];
          end
          m_idx++;
          armed = 1'b1; fcnt = 0; coll = 0;
        end
      end
    end else if (armed) begin
      fcnt++;
      if (fcnt >= 2 && fcnt <= 17) adc_miso = cur_code[17-fcnt];
      else if (fcnt >= 18)         adc_miso = cur_long;
    end
  end

  // Serial clock phase lengths.
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  always @(negedge clk) begin
    if (adc_cs_n) begin hi_run = 0; lo_run = 0; end
    else if (adc_sclk) begin
      if (lo_run != 0) last_lo = lo_run;
      lo_run = 0; hi_run++;
    end else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0; lo_run++;
    end
  end

  // Result recorder.
  logic [15:0] got_data [NVEC];
  logic [2:0]  got_chan [NVEC];
  int n_res = 0, wide = 0;
  logic prev_rv = 1'b0;
  always @(negedge clk) begin
    if (res_valid && prev_rv) wide++;
    if (res_valid && n_res < NVEC) begin
      got_data[n_res] = res_data;
      got_chan[n_res] = res_chan;
      n_res++;
    end
    prev_rv = res_valid;
  end

  task automatic check(input string req, input logic ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int i);
    @(negedge clk);
    cmd_chan   = VEC[i][22:20];
    cmd_single = VEC[i][19];
    cmd_pwr    = VEC[i][18:17];
    cmd_long   = VEC[i][16];
    cmd_valid  = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    return {1'b1, VEC[i][22:20], 1'b0, VEC[i][19], VEC[i][18:17]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pins", adc_cs_n && !adc_sclk && !adc_mosi && !res_valid && cmd_ready,
          {adc_cs_n, adc_sclk, adc_mosi, res_valid, cmd_ready}, 5'b10001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", adc_cs_n && !adc_sclk && !adc_mosi && cmd_ready,
          {adc_cs_n, adc_sclk, adc_mosi, cmd_ready}, 4'b1001);

    // Vector table walked back to back: overlaps wherever the next is short.
    for (int i = 0; i < 8; i++) send(i);
    @(negedge clk); cmd_valid = 1'b0;
    wait (n_win == 3);

    // Directed: lone long frame with all-ones padding (R7).
    send(8);
    @(negedge clk); cmd_valid = 1'b0;
    wait (n_win == 4);

    // Directed: command held while a short frame runs (R9, R5).
    send(9);
    @(negedge clk);
    cmd_chan = VEC[10][22:20]; cmd_single = VEC[10][19];
    cmd_pwr = VEC[10][18:17]; cmd_long = VEC[10][16];
    repeat (12) @(negedge clk);
    check("R9 ready low mid-frame", !cmd_ready, cmd_ready, 0);
    while (!cmd_ready) @(negedge clk);
    check("R5 overlap slot in clock high", adc_sclk && !adc_cs_n, {adc_sclk, adc_cs_n}, 2'b10);
    @(posedge clk);
    @(negedge clk); cmd_valid = 1'b0;
    wait (n_win == 5);
    wait (n_res == NVEC);
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      check("R2 control word", got_byte[i] == exp_byte(i), got_byte[i], exp_byte(i));
      if (VEC[i][16])
        check("R7 long result, padding ignored", got_data[i] == VEC[i][15:0], got_data[i], VEC[i][15:0]);
      else
        check("R4 result bits", got_data[i] == VEC[i][15:0], got_data[i], VEC[i][15:0]);
      check("R8 channel tag", got_chan[i] == VEC[i][22:20], got_chan[i], VEC[i][22:20]);
    end
    check("R8 result count", n_res == NVEC, n_res, NVEC);
    check("R8 single-cycle strobe", wide == 0, wide, 0);
    for (int w = 0; w < NWIN; w++)
      check((w == 2 || w == 4) ? "R6 window clocks" : "R5 R7 window clocks",
            got_win[w] == EXP_WIN[w], got_win[w], EXP_WIN[w]);
    check("R3 high phase", last_hi == DIV, last_hi, DIV);
    check("R3 low phase", last_lo == DIV, last_lo, DIV);
    check("R3 idle clock low", adc_cs_n && !adc_sclk, {adc_cs_n, adc_sclk}, 2'b10);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end
endmodule